// File: doc/BRIEF.md
# Basic-Block Checkpointing Register File

This block is an architectural register file that can restore, in one cycle, the register state from the start of the basic block now running. It holds two physical banks with one entry per register in each. A live selector bit per register names the bank that holds that register's current value. The first write to a register inside a block goes to the bank the selector does not name, and the selector bit then flips. The value the register had when the block began is therefore never overwritten. A written-in-block flag per register makes later writes in the same block reuse the new bank.

When a block ends, the core pulses the block-end strobe. The flags clear and the live selector mask is copied into a saved mask, which becomes the new restore point. When an exception forces a return to the block start, the core pulses the rollback strobe. The saved mask is copied back into the live mask and the flags clear, all in one cycle, and no data word moves. Two combinational read ports return the current value of any register. A register written in a given cycle shows its new value from the next cycle on.

Top module: `bbck_regfile`

## Requirements
- R1: After reset every register reads as zero on both read ports.
- R2: A register written in cycle N returns the written data on both read ports from cycle N+1 on, until it is written again or rolled back.
- R3: A read of a register in the same cycle that register is written returns its value from before the write.
- R4: A rollback pulse makes every register read the value it held at the most recent block-end pulse, or at reset if no block-end pulse has occurred.
- R5: Several writes to one register within a block do not disturb the restore point: after rollback that register reads its value from the start of the block.
- R6: A block-end pulse commits the block: a later rollback with no writes in between leaves every register at its current value.
- R7: A write in the same cycle as a block-end pulse belongs to the ending block, so its data survives a rollback that follows.
- R8: A write in the same cycle as a rollback pulse is discarded, and the register reads its value from the block start.
- R9: When block-end and rollback pulse in the same cycle, the rollback takes effect and the restore point stays where it was.
- R10: A register that is not written during a block keeps its value through a rollback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Register written |
| wr_data | input | DW | Data written |
| rd_addr_a | input | AW | Read port A register |
| rd_data_a | output | DW | Read port A data (combinational) |
| rd_addr_b | input | AW | Read port B register |
| rd_data_b | output | DW | Read port B data (combinational) |
| blk_end | input | 1 | Basic block finished: commit the restore point |
| rollback | input | 1 | Return to the start of the current block |

## Verification
Three actions can land in one cycle and must resolve in a fixed order: a write, a block-end commit and a rollback. The bench drives each pair together. It pairs a write with a block-end pulse, a write with a rollback, and a block-end pulse with a rollback. Each case is judged by a later rollback and a read of every register. The bench keeps two value arrays, live and restore point, and updates them with the priority from the requirements. It compares the RTL against them over directed cases and a long pseudo-random stream of mixed operations.

// File: rtl/bbck_pkg.sv
package bbck_pkg;

    typedef enum logic [1:0] {
        BB_RUN     = 2'd0,
        BB_COMMIT  = 2'd1,
        BB_RESTORE = 2'd2
    } bb_action_e;

    // rollback outranks commit; commit outranks plain running
    function automatic bb_action_e bb_decode(input logic end_i, input logic rb_i);
        if (rb_i)       return BB_RESTORE;
        else if (end_i) return BB_COMMIT;
        else            return BB_RUN;
    endfunction

endpackage

// File: rtl/bbck_mask_ctrl.sv
module bbck_mask_ctrl #(
    parameter int NREG = 16,
    localparam int AW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic            blk_end,
    input  logic            rollback,
    output logic            bank_we,
    output logic            bank_sel,
    output logic [NREG-1:0] state_q,
    output logic [NREG-1:0] dirty_q,
    output logic [NREG-1:0] saved_q
);
    import bbck_pkg::*;

    typedef struct packed {
        logic [NREG-1:0] state;
        logic [NREG-1:0] dirty;
        logic [NREG-1:0] saved;
    } mask_t;

    mask_t      cur_q, nxt_d;
    bb_action_e act;
    logic       first_wr;

    always_comb begin
        act      = bb_decode(blk_end, rollback);
        nxt_d    = cur_q;
        first_wr = !cur_q.dirty[wr_addr];
        bank_we  = wr_en && (act != BB_RESTORE);
        // first write in block lands in the opposite bank
        bank_sel = first_wr ? !cur_q.state[wr_addr] : cur_q.state[wr_addr];

        if (bank_we) begin
            nxt_d.state[wr_addr] = bank_sel;
            nxt_d.dirty[wr_addr] = 1'b1;
        end

        unique case (act)
            BB_RESTORE: begin
                nxt_d.state = cur_q.saved;
                nxt_d.dirty = '0;
            end
            BB_COMMIT: begin
                nxt_d.saved = nxt_d.state;
                nxt_d.dirty = '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign state_q = cur_q.state;
    assign dirty_q = cur_q.dirty;
    assign saved_q = cur_q.saved;

endmodule

// File: rtl/bbck_bank.sv
module bbck_bank #(
    parameter int   NREG    = 16,
    parameter int   DW      = 32,
    parameter logic BANK_ID = 1'b0,
    localparam int  AW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic                     sel,
    input  logic [AW-1:0]            waddr,
    input  logic [DW-1:0]            wdata,
    output logic [NREG-1:0][DW-1:0]  mem_q
);
    logic [NREG-1:0][DW-1:0] mem_d;

    always_comb begin
        mem_d = mem_q;
        if (we && (sel == BANK_ID)) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

endmodule

// File: rtl/bbck_read_port.sv
module bbck_read_port #(
    parameter int  NREG = 16,
    parameter int  DW   = 32,
    localparam int AW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic [AW-1:0]           addr,
    input  logic [NREG-1:0]         state,
    input  logic [NREG-1:0][DW-1:0] bank0,
    input  logic [NREG-1:0][DW-1:0] bank1,
    output logic [DW-1:0]           data
);
    always_comb begin
        data = state[addr] ? bank1[addr] : bank0[addr];
    end

endmodule

// File: rtl/bbck_regfile.sv
module bbck_regfile #(
    parameter int  NREG = 16,
    parameter int  DW   = 32,
    localparam int AW = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int NRD = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr_a,
    output logic [DW-1:0] rd_data_a,
    input  logic [AW-1:0] rd_addr_b,
    output logic [DW-1:0] rd_data_b,
    input  logic          blk_end,
    input  logic          rollback
);
    logic                    bank_we;
    logic                    bank_sel;
    logic [NREG-1:0]         state_q;
    logic [NREG-1:0]         dirty_q;
    logic [NREG-1:0]         saved_q;
    logic [1:0][NREG-1:0][DW-1:0] banks;
    logic [NRD-1:0][AW-1:0]  rd_addr;
    logic [NRD-1:0][DW-1:0]  rd_data;

    bbck_mask_ctrl #(.NREG(NREG)) u_masks (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .blk_end  (blk_end),
        .rollback (rollback),
        .bank_we  (bank_we),
        .bank_sel (bank_sel),
        .state_q  (state_q),
        .dirty_q  (dirty_q),
        .saved_q  (saved_q)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        bbck_bank #(.NREG(NREG), .DW(DW), .BANK_ID(b[0])) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we),
            .sel   (bank_sel),
            .waddr (wr_addr),
            .wdata (wr_data),
            .mem_q (banks[b])
        );
    end

    assign rd_addr[0] = rd_addr_a;
    assign rd_addr[1] = rd_addr_b;

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        bbck_read_port #(.NREG(NREG), .DW(DW)) u_rd (
            .addr  (rd_addr[p]),
            .state (state_q),
            .bank0 (banks[0]),
            .bank1 (banks[1]),
            .data  (rd_data[p])
        );
    end

    assign rd_data_a = rd_data[0];
    assign rd_data_b = rd_data[1];

endmodule

// File: rtl/bbck_regfile_chk.sv
module bbck_regfile_chk #(
    parameter int  NREG = 16,
    localparam int AW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [AW-1:0]   wr_addr,
    input logic            blk_end,
    input logic            rollback,
    input logic [NREG-1:0] state_q,
    input logic [NREG-1:0] dirty_q,
    input logic [NREG-1:0] saved_q
);
    // R5: first write in a block flips the bank selector
    a_r5_first_write_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rollback && !dirty_q[wr_addr])
        |=> (state_q[$past(wr_addr)] != $past(state_q[wr_addr])));

    // R5: later writes in the same block keep the selector
    a_r5_repeat_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rollback && dirty_q[wr_addr])
        |=> (state_q[$past(wr_addr)] == $past(state_q[wr_addr])));

    // R4: rollback restores the saved mapping and clears the flags
    a_r4_rollback_restores: assert property (@(posedge clk) disable iff (!rst_n)
        rollback |=> (state_q == $past(saved_q)) && (dirty_q == '0));

    // R6: commit clears the flags and makes the live mapping the restore point
    a_r6_commit_saves: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_end && !rollback) |=> (dirty_q == '0) && (saved_q == state_q));

    // R9: restore point moves only on a commit that is not overridden
    a_r9_restore_point_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(blk_end && !rollback) |=> $stable(saved_q));

    // R10: without a write or rollback the mapping does not move
    a_r10_mapping_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rollback) |=> $stable(state_q));

endmodule

bind bbck_regfile bbck_regfile_chk #(.NREG(NREG)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .blk_end  (blk_end),
    .rollback (rollback),
    .state_q  (state_q),
    .dirty_q  (dirty_q),
    .saved_q  (saved_q)
);

// File: tb/bbck_regfile_test.sv
module bbck_regfile_test;
    localparam int NREG = 16;
    localparam int DW   = 32;
    localparam int AW   = $clog2(NREG);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en, blk_end, rollback;
    logic [AW-1:0] wr_addr, rd_addr_a, rd_addr_b;
    logic [DW-1:0] wr_data, rd_data_a, rd_data_b;

    logic [DW-1:0] live [NREG];
    logic [DW-1:0] ckpt [NREG];
    int checks = 0;
    int failures = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #4 clk = ~clk;

    bbck_regfile #(.NREG(NREG), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .blk_end(blk_end), .rollback(rollback)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int r, input int k);
        return (32'h9E37_79B9 * (r + 1)) ^ (32'h0101_0101 * k) ^ 32'(k << 4);
    endfunction

    // one clock of activity; bench model follows the stated priority
    task automatic cyc(input logic we, input int a, input logic [DW-1:0] d,
                       input logic be, input logic rb);
        @(negedge clk);
        wr_en = we; wr_addr = AW'(a); wr_data = d; blk_end = be; rollback = rb;
        rd_addr_a = AW'(a); rd_addr_b = AW'(a);
        #1;
        if (we) begin
            check("R3 same-cycle read port A", rd_data_a, live[a]);
            check("R3 same-cycle read port B", rd_data_b, live[a]);
        end
        @(posedge clk);
        if (rb) begin
            for (int i = 0; i < NREG; i++) live[i] = ckpt[i];
        end else begin
            if (we) live[a] = d;
            if (be) for (int i = 0; i < NREG; i++) ckpt[i] = live[i];
        end
        #1;
        wr_en = 0; blk_end = 0; rollback = 0;
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < NREG; i++) begin
            @(negedge clk);
            wr_en = 0; blk_end = 0; rollback = 0;
            rd_addr_a = AW'(i); rd_addr_b = AW'(NREG - 1 - i);
            #1;
            check(tag, rd_data_a, live[i]);
            check(tag, rd_data_b, live[NREG - 1 - i]);
        end
    endtask

    initial begin : watchdog
        #1_000_000;
        failures++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 0; wr_en = 0; blk_end = 0; rollback = 0;
        wr_addr = '0; wr_data = '0; rd_addr_a = '0; rd_addr_b = '0;
        for (int i = 0; i < NREG; i++) begin live[i] = '0; ckpt[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        read_all("R1 reset value");

        // full sweep of writes, then commit and a no-op rollback
        for (int i = 0; i < NREG; i++) cyc(1, i, pat(i, 1), 0, 0);
        read_all("R2 write visible");
        cyc(0, 0, '0, 1, 0);
        cyc(0, 0, '0, 0, 1);
        read_all("R6 commit then rollback");

        // even registers written twice, odd untouched, then rollback
        for (int i = 0; i < NREG; i += 2) begin
            cyc(1, i, pat(i, 2), 0, 0);
            cyc(1, i, pat(i, 3), 0, 0);
        end
        read_all("R2 repeat write visible");
        cyc(0, 0, '0, 0, 1);
        read_all("R5 R4 R10 rollback after repeat writes");

        // write in the commit cycle
        cyc(1, 3, pat(3, 4), 0, 0);
        cyc(1, 5, pat(5, 4), 1, 0);
        cyc(1, 5, pat(5, 5), 0, 0);
        cyc(0, 0, '0, 0, 1);
        read_all("R7 write with block end");

        // write in the rollback cycle
        cyc(1, 7, pat(7, 6), 0, 0);
        cyc(1, 9, pat(9, 6), 0, 1);
        read_all("R8 write with rollback");

        // block end and rollback together
        cyc(1, 2, pat(2, 7), 0, 0);
        cyc(0, 0, '0, 1, 1);
        read_all("R9 rollback beats block end");
        cyc(1, 2, pat(2, 8), 0, 0);
        cyc(0, 0, '0, 0, 1);
        read_all("R9 restore point unchanged");

        // pseudo-random mixed stream
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            cyc(lfsr[3] | lfsr[4], int'(lfsr[11:8]) % NREG, pat(n, int'(lfsr[19:12])),
                (lfsr[7:5] == 3'd0), (lfsr[15:13] == 3'd7));
            if (n % 250 == 249) read_all("R2 R4 mixed stream");
        end
        read_all("R4 final");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule